// File: doc/BRIEF.md
# Sixteen-Bit ALU with Carry and Zero Flags

This block is the arithmetic logic unit of a small processor datapath, together with its two-bit status register. The controller presents two 16-bit operands, called left (`a`) and right (`b`), and a 4-bit operation code. The unit computes the result combinationally and drives it toward the data bus through an output enable. When the enable is low, it drives zero instead of tri-stating.

The stored carry is an input to every carry-aware operation. Add uses it as carry-in and subtract uses it as borrow-in. The one-bit shifts use it as the bit shifted in, so a shift is a rotate through carry. Compare changes only the flags and never produces a data value.

The flags are written at the clock edge, and only when the controller raises `flag_en`. Two further strobes force the carry to 0 or to 1. They act in the same edge as an ordinary flag update and override its carry.

Top module: `alu_flags`

## Requirements
- R1: While `rst_n` is low, both `c_flag` and `z_flag` are 0, and they stay 0 until the first flag write after reset.
- R2: The logic operations give these results: op 0 gives `a & b`, op 1 gives `a | b`, and op 2 gives `~b`.
- R3: Op 5 (add) gives `a + b + c_flag` in 16 bits. When `flag_en` is high, the carry out of bit 15 is stored into `c_flag`.
- R4: Op 6 (subtract) gives `a - b - c_flag` in 16 bits. When `flag_en` is high, `c_flag` stores 1 exactly when a borrow is needed, that is when `a < b + c_flag`.
- R5: Op 3 (shift left) gives `{a[14:0], c_flag}` and stores `a[15]` into carry. Op 4 (shift right) gives `{c_flag, a[15:1]}` and stores `a[0]` into carry. The carry is stored only when `flag_en` is high.
- R6: Op 7 (multiply) gives the 16-bit product of `a[7:0]` and `b[7:0]`.
- R7: Op 8 (compare) drives a result of 0. When `flag_en` is high, it sets `z_flag` to `a == b` and `c_flag` to `a < b`, both unsigned.
- R8: For ops 0 to 7, when `flag_en` is high, `z_flag` stores whether the 16-bit result is zero. Ops 0, 1, 2 and 7 leave `c_flag` unchanged.
- R9: When `flag_en`, `clr_c` and `set_c` are all low, neither flag changes at the clock edge.
- R10: `clr_c` forces `c_flag` to 0 at the next edge, and `set_c` forces it to 1. If both are high, clear wins. Either strobe overrides a carry written by `flag_en` in the same edge, and `z_flag` still updates normally in that edge.
- R11: While `out_en` is low, `result` is 0 whatever the operation.
- R12: Op codes 9 to 15 drive a result of 0 and leave both flags unchanged, even when `flag_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the flags |
| a | input | 16 | Left operand |
| b | input | 16 | Right operand |
| op | input | 4 | Operation code (0 AND, 1 OR, 2 NOT, 3 SHL, 4 SHR, 5 ADD, 6 SUB, 7 MUL, 8 CMP) |
| flag_en | input | 1 | Store the operation's flags at the clock edge |
| clr_c | input | 1 | Force carry to 0 |
| set_c | input | 1 | Force carry to 1 |
| out_en | input | 1 | Drive the result; zero when low |
| result | output | 16 | Operation result |
| c_flag | output | 1 | Stored carry/borrow flag |
| z_flag | output | 1 | Stored zero flag |

## Verification
Two functions can meet in the same edge: an ordinary flag write through `flag_en`, and a forced carry through `clr_c` or `set_c`. The bench provokes this with an add whose carry out is 1 and whose result is zero, issued together with `clr_c`. The carry must read 0 while the zero flag still reads 1. The bench then raises `set_c` alone during a logic operation, and finally raises both strobes together, where the clear must win. Carry feedback is checked by chaining operations, so that each expected sum, difference or shifted value depends on the carry the previous step left behind.

// File: rtl/alu_flags.sv
module alu_flags #(
  parameter int W   = 16,
  parameter int OPW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic [OPW-1:0] op,
  input  logic           flag_en,
  input  logic           clr_c,
  input  logic           set_c,
  input  logic           out_en,
  output logic [W-1:0]   result,
  output logic           c_flag,
  output logic           z_flag
);
  localparam int H = W / 2;
  localparam logic [OPW-1:0] OP_AND = 0, OP_OR = 1, OP_NOT = 2, OP_SHL = 3,
                             OP_SHR = 4, OP_ADD = 5, OP_SUB = 6, OP_MUL = 7,
                             OP_CMP = 8;

  logic [W-1:0] raw;
  logic         c_nx, z_nx, upd_c, known;
  logic [W:0]   sum, dif;

  assign sum = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, c_flag};
  assign dif = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, c_flag};

  always_comb begin
    raw   = '0;
    c_nx  = c_flag;
    upd_c = 1'b0;
    known = 1'b1;
    case (op)
      OP_AND: raw = a & b;
      OP_OR:  raw = a | b;
      OP_NOT: raw = ~b;
      OP_SHL: begin raw = {a[W-2:0], c_flag}; c_nx = a[W-1]; upd_c = 1'b1; end
      OP_SHR: begin raw = {c_flag, a[W-1:1]}; c_nx = a[0];   upd_c = 1'b1; end
      OP_ADD: begin raw = sum[W-1:0]; c_nx = sum[W]; upd_c = 1'b1; end
      OP_SUB: begin raw = dif[W-1:0]; c_nx = dif[W]; upd_c = 1'b1; end
      OP_MUL: raw = a[H-1:0] * b[H-1:0];
      OP_CMP: begin c_nx = (a < b); upd_c = 1'b1; end
      default: known = 1'b0;
    endcase
    z_nx = (op == OP_CMP) ? (a == b) : (raw == '0);
  end

  assign result = out_en ? raw : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_flag <= 1'b0;
      z_flag <= 1'b0;
    end else begin
      if (flag_en && known) begin
        z_flag <= z_nx;
        if (upd_c) c_flag <= c_nx;
      end
      if (clr_c)      c_flag <= 1'b0;
      else if (set_c) c_flag <= 1'b1;
    end
  end
endmodule

module alu_flags_chk #(
  parameter int W   = 16,
  parameter int OPW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [W-1:0]   a,
  input logic [W-1:0]   b,
  input logic [OPW-1:0] op,
  input logic           flag_en,
  input logic           clr_c,
  input logic           set_c,
  input logic           out_en,
  input logic [W-1:0]   result,
  input logic           c_flag,
  input logic           z_flag
);
  // R11
  out_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en |-> result == '0);
  // R9
  flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flag_en && !clr_c && !set_c) |=> ($stable(c_flag) && $stable(z_flag)));
  // R10
  clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_c |=> !c_flag);
  // R10
  set_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_c && !clr_c) |=> c_flag);
  // R7
  cmp_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_en && op == OPW'(8) && !clr_c && !set_c)
      |=> (z_flag == $past(a == b)) && (c_flag == $past(a < b)));
  // R7
  cmp_nores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op == OPW'(8) |-> result == '0);
  // R12
  bad_op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op > OPW'(8) && !clr_c && !set_c) |=> ($stable(c_flag) && $stable(z_flag)));
endmodule

bind alu_flags alu_flags_chk #(.W(W), .OPW(OPW)) u_alu_flags_chk (
  .clk(clk), .rst_n(rst_n), .a(a), .b(b), .op(op), .flag_en(flag_en),
  .clr_c(clr_c), .set_c(set_c), .out_en(out_en), .result(result),
  .c_flag(c_flag), .z_flag(z_flag));

// File: tb/test_alu_flags.sv
module test_alu_flags;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] a = '0, b = '0;
  logic [3:0]  op = '0;
  logic        flag_en = 1'b0, clr_c = 1'b0, set_c = 1'b0, out_en = 1'b1;
  logic [15:0] result;
  logic        c_flag, z_flag;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  alu_flags i_alu_flags (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .op(op), .flag_en(flag_en),
    .clr_c(clr_c), .set_c(set_c), .out_en(out_en), .result(result),
    .c_flag(c_flag), .z_flag(z_flag));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one operation, check result, clock it, then check the flags.
  task automatic step(input string tag, input logic [3:0] o, input logic [15:0] x,
                      input logic [15:0] y, input logic fe, input logic cl,
                      input logic st, input logic oe, input logic [15:0] er,
                      input logic ec, input logic ez);
    @(negedge clk);
    op = o; a = x; b = y; flag_en = fe; clr_c = cl; set_c = st; out_en = oe;
    #1 chk({tag, " result"}, result, er);
    @(posedge clk);
    @(negedge clk);
    flag_en = 0; clr_c = 0; set_c = 0; out_en = 1;
    chk({tag, " carry"}, {15'b0, c_flag}, {15'b0, ec});
    chk({tag, " zero"}, {15'b0, z_flag}, {15'b0, ez});
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 reset carry", {15'b0, c_flag}, 16'h0);
    chk("R1 reset zero", {15'b0, z_flag}, 16'h0);
  endtask

  task automatic t_logic;
    step("R2 and", 4'd0, 16'hF0F0, 16'hFF00, 0, 0, 0, 1, 16'hF000, 0, 0);
    step("R2 or",  4'd1, 16'hF0F0, 16'hFF00, 0, 0, 0, 1, 16'hFFF0, 0, 0);
    step("R2 not", 4'd2, 16'hF0F0, 16'hFF00, 0, 0, 0, 1, 16'h00FF, 0, 0);
    step("R8 and zero", 4'd0, 16'h00FF, 16'hFF00, 1, 0, 0, 1, 16'h0000, 0, 1);
  endtask

  task automatic t_add;
    step("R3 add carry out", 4'd5, 16'hFFFF, 16'h0001, 1, 0, 0, 1, 16'h0000, 1, 1);
    step("R3 add carry in",  4'd5, 16'h0001, 16'h0001, 1, 0, 0, 1, 16'h0003, 0, 0);
  endtask

  task automatic t_sub;
    step("R4 sub borrow out", 4'd6, 16'h0005, 16'h0007, 1, 0, 0, 1, 16'hFFFE, 1, 0);
    step("R4 sub borrow in",  4'd6, 16'h0005, 16'h0003, 1, 0, 0, 1, 16'h0001, 0, 0);
  endtask

  task automatic t_shift;
    step("R10 set before shift", 4'd0, 16'h0001, 16'h0001, 0, 0, 1, 1, 16'h0001, 1, 0);
    step("R5 shl", 4'd3, 16'h8001, 16'h0000, 1, 0, 0, 1, 16'h0003, 1, 0);
    step("R5 shr", 4'd4, 16'h0002, 16'h0000, 1, 0, 0, 1, 16'h8001, 0, 0);
  endtask

  task automatic t_mul;
    step("R6 mul high bytes ignored", 4'd7, 16'h12FF, 16'h34FF, 1, 0, 0, 1, 16'hFE01, 0, 0);
    step("R6 mul small", 4'd7, 16'h0010, 16'h0010, 0, 0, 0, 1, 16'h0100, 0, 0);
    step("R8 mul zero keeps carry", 4'd7, 16'h0100, 16'h0005, 1, 0, 0, 1, 16'h0000, 0, 1);
  endtask

  task automatic t_cmp;
    step("R7 cmp equal", 4'd8, 16'h1234, 16'h1234, 1, 0, 0, 1, 16'h0000, 0, 1);
    step("R7 cmp less",  4'd8, 16'h0001, 16'h0002, 1, 0, 0, 1, 16'h0000, 1, 0);
    step("R7 cmp greater", 4'd8, 16'h8000, 16'h0002, 1, 0, 0, 1, 16'h0000, 0, 0);
  endtask

  task automatic t_hold;
    step("R9 no flag write", 4'd5, 16'hFFFF, 16'h0001, 0, 0, 0, 1, 16'h0000, 0, 0);
  endtask

  task automatic t_force;
    step("R10 clear over add carry", 4'd5, 16'hFFFF, 16'h0001, 1, 1, 0, 1, 16'h0000, 0, 1);
    step("R10 set with and", 4'd0, 16'h0F00, 16'h0F00, 1, 0, 1, 1, 16'h0F00, 1, 0);
    step("R10 both strobes", 4'd0, 16'h0000, 16'h0000, 0, 1, 1, 1, 16'h0000, 0, 0);
  endtask

  task automatic t_oe;
    step("R11 output disabled", 4'd1, 16'h1234, 16'h4321, 0, 0, 0, 0, 16'h0000, 0, 0);
  endtask

  task automatic t_badop;
    step("R10 set before bad op", 4'd0, 16'h0001, 16'h0001, 1, 0, 1, 1, 16'h0001, 1, 0);
    step("R12 op 9", 4'd9, 16'h0000, 16'h0000, 1, 0, 0, 1, 16'h0000, 1, 0);
    step("R12 op 15", 4'd15, 16'hFFFF, 16'hFFFF, 1, 0, 0, 1, 16'h0000, 1, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_logic();
    t_add();
    t_sub();
    t_shift();
    t_mul();
    t_cmp();
    t_hold();
    t_force();
    t_oe();
    t_badop();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule